// File: doc/BRIEF.md
# Exponential Period Monitor with Trip Outputs

This block estimates how fast a positive, slowly varying quantity (a count rate or a power reading) grows. It takes averaged samples at a fixed interval and works out the e-folding time from each pair of neighbouring samples. Every new sample `P(k)`, together with the sample before it `P(k-1)` and the sampling interval `dt_ms` in milliseconds, gives a period in whole seconds. The formula is `T = dt_ms * P(k-1) / (1000 * (P(k) - P(k-1)))`, rounded down. Each result is limited to the range 0 to 999 s.

Only a rising signal counts as a hazard. When the signal is flat or falling, the block reports 999 s, which stands for stable, and keeps both trip flags low. A growing signal with a short period raises a warning flag, and a shorter period also raises an emergency flag. Each flag is set by comparing the period with its own threshold input. The division is done by a restoring divider that takes one quotient bit per cycle. A sample that arrives while the divider is busy is held in a single pending slot and is processed as soon as the divider is free.

Top module: `efold_period_mon`

## Requirements
- R1: For a rising pair (`P(k) > P(k-1)`), `period_s` equals the rounded-down value of `dt_ms*P(k-1) / (1000*(P(k)-P(k-1)))` whenever that value is 999 or less.
- R2: When two consecutive samples are equal, `period_s` is 999 and both `trip_warn` and `trip_emer` are 0.
- R3: When a sample is smaller than the one before it, `period_s` is 999 and both trip flags are 0, whatever the thresholds.
- R4: For a rising pair whose quotient is above 999, `period_s` saturates to 999.
- R5: For a rising pair, `trip_warn` is 1 exactly when `period_s < thr_warn`, and `trip_emer` is 1 exactly when `period_s < thr_emer`.
- R6: A step large enough to make the quotient 0 reports `period_s` = 0, and both flags are 1 for any nonzero thresholds.
- R7: The first sample after reset only sets the reference and produces no result. Each later accepted sample produces exactly one `period_valid` pulse.
- R8: `period_valid` is a one-cycle pulse. It is high in the cycle after the (SAMPLE_W+DT_W+1)-th rising clock edge that follows the edge that takes the sample, which is 27 edges at the default widths.
- R9: A sample that arrives while a division is running is held. After the current result, it produces its own result, computed against the sample that came just before it.
- R10: `period_s`, `trip_warn` and `trip_emer` change only at the `period_valid` strobe, and hold their values between strobes.
- R11: While in reset and after it, `period_s` is 999, and `period_valid`, `trip_warn` and `trip_emer` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Strobe: `sample` carries a new averaged value |
| sample | input | SAMPLE_W | Averaged power or rate sample, unsigned |
| dt_ms | input | DT_W | Sampling interval in milliseconds |
| thr_warn | input | 10 | Warning threshold in seconds |
| thr_emer | input | 10 | Emergency threshold in seconds |
| period_s | output | 10 | Period in whole seconds, 0 to 999 |
| period_valid | output | 1 | One-cycle strobe marking a new period result |
| trip_warn | output | 1 | Period below the warning threshold on a rising signal |
| trip_emer | output | 1 | Period below the emergency threshold on a rising signal |

## Verification
The hardest state to reach from the ports is a sample arriving while the divider is in the middle of a division. The pending slot must then be paired with the right reference value. To get there, the bench sends a second sample one cycle after the first. It then expects two results in order: the first against the old reference, and the second against the first sample. The other hard corners are a zero quotient, which needs a very small old value and a very large new one, and saturation above 999. The bench reaches both through a sweep over old values and step sizes at several sampling intervals and threshold pairs.

// File: rtl/efold_pkg.sv
package efold_pkg;
  localparam int unsigned MS_PER_S   = 1000;
  localparam int unsigned SCALE_W    = 10;
  localparam int unsigned PER_W      = 10;
  localparam logic [PER_W-1:0] PER_STABLE = 10'd999;
endpackage

// File: rtl/efold_divider.sv
module efold_divider #(
  parameter int unsigned NUM_W = 26,
  parameter int unsigned DEN_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, rem_d;
  logic [DEN_W-1:0] den_q, den_d;
  logic [NUM_W-1:0] quo_q, quo_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [DEN_W:0]   shifted;
  logic [DEN_W:0]   trial;

  always_comb begin
    rem_d   = rem_q;
    den_d   = den_q;
    quo_d   = quo_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    shifted = {rem_q, quo_q[NUM_W-1]};
    trial   = shifted - {1'b0, den_q};
    if (start) begin
      rem_d = '0;
      den_d = den;
      quo_d = num;
      cnt_d = CNT_W'(NUM_W);
    end else if (cnt_q != '0) begin
      if (!trial[DEN_W]) begin
        rem_d = trial[DEN_W-1:0];
        quo_d = {quo_q[NUM_W-2:0], 1'b1};
      end else begin
        rem_d = shifted[DEN_W-1:0];
        quo_d = {quo_q[NUM_W-2:0], 1'b0};
      end
      cnt_d  = cnt_q - 1'b1;
      done_d = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      den_q  <= den_d;
      quo_q  <= quo_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign busy = (cnt_q != '0);
  assign done = done_q;
  assign quot = quo_q;
endmodule

// File: rtl/efold_trip.sv
module efold_trip
  import efold_pkg::*;
#(
  parameter int unsigned NUM_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             rising,
  input  logic [NUM_W-1:0] quot,
  input  logic [PER_W-1:0] thr_warn,
  input  logic [PER_W-1:0] thr_emer,
  output logic [PER_W-1:0] period_s,
  output logic             period_valid,
  output logic             trip_warn,
  output logic             trip_emer
);
  logic [PER_W-1:0] per_q, per_d;
  logic             warn_q, warn_d;
  logic             emer_q, emer_d;
  logic             vld_q;
  logic [PER_W-1:0] sat;

  always_comb begin
    if (!rising || (quot > NUM_W'(PER_STABLE))) sat = PER_STABLE;
    else                                         sat = quot[PER_W-1:0];
    per_d  = per_q;
    warn_d = warn_q;
    emer_d = emer_q;
    if (load) begin
      per_d  = sat;
      warn_d = rising && (sat < thr_warn);
      emer_d = rising && (sat < thr_emer);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= PER_STABLE;
      warn_q <= 1'b0;
      emer_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      per_q  <= per_d;
      warn_q <= warn_d;
      emer_q <= emer_d;
      vld_q  <= load;
    end
  end

  assign period_s     = per_q;
  assign period_valid = vld_q;
  assign trip_warn    = warn_q;
  assign trip_emer    = emer_q;
endmodule

// File: rtl/efold_period_mon.sv
module efold_period_mon
  import efold_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned DT_W     = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_valid,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [DT_W-1:0]     dt_ms,
  input  logic [PER_W-1:0]    thr_warn,
  input  logic [PER_W-1:0]    thr_emer,
  output logic [PER_W-1:0]    period_s,
  output logic                period_valid,
  output logic                trip_warn,
  output logic                trip_emer
);
  localparam int unsigned NUM_W = SAMPLE_W + DT_W;
  localparam int unsigned DEN_W = SAMPLE_W + SCALE_W;

  logic [SAMPLE_W-1:0] prev_q, prev_d;
  logic                have_q, have_d;
  logic [SAMPLE_W-1:0] pend_q, pend_d;
  logic                pendv_q, pendv_d;
  logic                rise_q, rise_d;

  logic                div_busy, div_done, div_start;
  logic                launch_pend, launch_new;
  logic [SAMPLE_W-1:0] op_cur, step;
  logic                op_rise;
  logic [NUM_W-1:0]    op_num, div_quot;
  logic [DEN_W-1:0]    op_den;

  always_comb begin
    launch_pend = pendv_q && !div_busy;
    launch_new  = sample_valid && have_q && !div_busy && !pendv_q;
    div_start   = launch_pend || launch_new;
    op_cur      = launch_pend ? pend_q : sample;
    op_rise     = op_cur > prev_q;
    step        = op_cur - prev_q;
    op_num      = NUM_W'(dt_ms) * NUM_W'(prev_q);
    op_den      = op_rise ? DEN_W'(step) * DEN_W'(MS_PER_S) : DEN_W'(1);

    prev_d  = prev_q;
    have_d  = have_q;
    pend_d  = pend_q;
    pendv_d = pendv_q;
    rise_d  = rise_q;
    if (sample_valid && !have_q) begin
      prev_d = sample;
      have_d = 1'b1;
    end
    if (div_start) begin
      prev_d = op_cur;
      rise_d = op_rise;
    end
    if (launch_pend) pendv_d = 1'b0;
    if (sample_valid && have_q && (div_busy || pendv_q)) begin
      pend_d  = sample;
      pendv_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      have_q  <= 1'b0;
      pend_q  <= '0;
      pendv_q <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      have_q  <= have_d;
      pend_q  <= pend_d;
      pendv_q <= pendv_d;
      rise_q  <= rise_d;
    end
  end

  efold_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (op_num),
    .den   (op_den),
    .busy  (div_busy),
    .done  (div_done),
    .quot  (div_quot)
  );

  efold_trip #(.NUM_W(NUM_W)) u_trip (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (div_done),
    .rising       (rise_q),
    .quot         (div_quot),
    .thr_warn     (thr_warn),
    .thr_emer     (thr_emer),
    .period_s     (period_s),
    .period_valid (period_valid),
    .trip_warn    (trip_warn),
    .trip_emer    (trip_emer)
  );
endmodule

// File: rtl/efold_period_mon_chk.sv
module efold_period_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [9:0] thr_warn,
  input logic [9:0] thr_emer,
  input logic [9:0] period_s,
  input logic       period_valid,
  input logic       trip_warn,
  input logic       trip_emer,
  input logic       div_busy,
  input logic       div_start
);
  assert_period_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    period_valid |-> period_s <= 10'd999);

  assert_outputs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !period_valid |-> ($stable(period_s) && $stable(trip_warn) && $stable(trip_emer)));

  assert_strobe_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    period_valid |=> !period_valid);

  assert_no_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> !div_start);

  assert_emer_implies_warn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (period_valid && trip_emer && (thr_emer <= thr_warn) && $stable(thr_warn) && $stable(thr_emer))
      |-> trip_warn);

  assert_stable_no_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (period_valid && (period_s == 10'd999) && (thr_warn <= 10'd999) && $stable(thr_warn))
      |-> !trip_warn);
endmodule

bind efold_period_mon efold_period_mon_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .thr_warn     (thr_warn),
  .thr_emer     (thr_emer),
  .period_s     (period_s),
  .period_valid (period_valid),
  .trip_warn    (trip_warn),
  .trip_emer    (trip_emer),
  .div_busy     (div_busy),
  .div_start    (div_start)
);

// File: tb/efold_period_mon_bench.sv
`timescale 1ns/1ps
module efold_period_mon_bench;
  localparam int SW = 16;
  localparam int DW = 10;
  localparam int LAT = SW + DW + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sample_valid;
  logic [SW-1:0] sample;
  logic [DW-1:0] dt_ms;
  logic [9:0]    thr_warn, thr_emer;
  logic [9:0]    period_s;
  logic          period_valid, trip_warn, trip_emer;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  longint ref_prev;
  bit lat_checked = 0;

  always #4 clk = ~clk;

  efold_period_mon #(.SAMPLE_W(SW), .DT_W(DW)) u_efold_period_mon (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample(sample),
    .dt_ms(dt_ms), .thr_warn(thr_warn), .thr_emer(thr_emer),
    .period_s(period_s), .period_valid(period_valid),
    .trip_warn(trip_warn), .trip_emer(trip_emer)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input longint v);
    @(negedge clk);
    sample_valid = 1'b1;
    sample = SW'(v);
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic wait_result(output int lat);
    lat = 0;
    while (!period_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic expect_pair(input longint p0, input longint p1);
    longint q, ep;
    bit ew, ee;
    string tag;
    if (p1 <= p0) begin
      ep = 999; ew = 0; ee = 0;
      tag = (p1 == p0) ? "R2" : "R3";
    end else begin
      q = (longint'(dt_ms) * p0) / (1000 * (p1 - p0));
      ep = (q > 999) ? 999 : q;
      ew = ep < thr_warn;
      ee = ep < thr_emer;
      tag = (q > 999) ? "R4" : ((q == 0) ? "R6" : "R1/R5");
    end
    chk(period_valid == 1'b1, tag, "strobe", period_valid, 1);
    chk(period_s == ep[9:0] && trip_warn == ew && trip_emer == ee, tag,
        "period*4+warn*2+emer", period_s*4 + trip_warn*2 + trip_emer, ep*4 + ew*2 + ee);
  endtask

  task automatic job(input longint v);
    int lat;
    drive(v);
    wait_result(lat);
    if (!lat_checked) begin
      chk(lat == LAT, "R8", "latency", lat, LAT);
      lat_checked = 1;
    end
    expect_pair(ref_prev, v);
    ref_prev = v;
  endtask

  initial begin
    int lat;
    logic [9:0] hp;
    logic hw, he;
    longint prevs[6] = '{1, 7, 100, 1000, 4000, 65000};
    longint deltas[9] = '{-2, -1, 0, 1, 2, 5, 13, 100, 1000};
    int dts[3] = '{20, 100, 1023};
    rst_n = 1'b0;
    sample_valid = 1'b0;
    sample = '0;
    dt_ms = 10'd100;
    thr_warn = 10'd40;
    thr_emer = 10'd20;
    repeat (3) @(negedge clk);
    chk(period_s == 999 && !period_valid && !trip_warn && !trip_emer, "R11",
        "reset outputs", {period_s, period_valid, trip_warn, trip_emer}, 999 * 8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(period_s == 999 && !period_valid, "R11", "after release", period_s, 999);

    // R7: first sample sets the reference only
    drive(1000);
    ref_prev = 1000;
    wait_result(lat);
    chk(lat >= 200, "R7", "no result for first sample", lat, 200);

    // R1 / R8: rising pair, 100*1000/(1000*10) = 10
    job(1010);
    // R10: outputs hold between strobes
    hp = period_s; hw = trip_warn; he = trip_emer;
    repeat (6) @(negedge clk);
    chk(period_s == hp && trip_warn == hw && trip_emer == he && !period_valid,
        "R10", "hold", period_s, hp);

    // R6: huge step at dt=1 gives quotient 0
    dt_ms = 10'd1;
    job(1);
    job(65535);

    // R9: second sample arrives while the divider is busy
    dt_ms = 10'd100;
    job(200);
    @(negedge clk);
    sample_valid = 1'b1; sample = 16'd210;
    @(negedge clk);
    sample = 16'd230;
    @(negedge clk);
    sample_valid = 1'b0;
    wait_result(lat);
    chk(period_valid, "R9", "first of held pair", period_valid, 1);
    expect_pair(200, 210);
    @(negedge clk);
    wait_result(lat);
    chk(period_valid, "R9", "held sample result", period_valid, 1);
    expect_pair(210, 230);
    ref_prev = 230;

    // sweep: thresholds x interval x reference x step
    for (int t = 0; t < 2; t++) begin
      thr_warn = (t == 0) ? 10'd40 : 10'd700;
      thr_emer = (t == 0) ? 10'd20 : 10'd300;
      for (int d = 0; d < 3; d++) begin
        dt_ms = DW'(dts[d]);
        for (int p = 0; p < 6; p++) begin
          for (int s = 0; s < 9; s++) begin
            longint nv;
            nv = prevs[p] + deltas[s];
            if (nv < 0) nv = 0;
            if (nv > 65535) nv = 65535;
            job(prevs[p]);
            job(nv);
          end
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule